// File: doc/BRIEF.md
# Typed-Block Chaining Sequencer

This block is the chaining-mode controller that sits in front of an external tweakable block cipher with a 512-bit block. A hash is built as a chain of typed segments. An optional key segment comes first, then the configuration segment, then any later segments in rising type order. Each segment is split into 64-byte blocks. For every block the sequencer builds a 128-bit tweak, hands the current chaining value to the cipher as the key and the zero-filled block as the plaintext, and folds the result back into the chaining value. When the digest is requested, the sequencer runs an output stage. This stage enciphers a block that holds a 64-bit counter under the output type, once per 512 bits of digest. It then emits the results with every bit beyond the requested length cleared.

The cipher is reached through a request/acknowledge port. The sequencer holds key, tweak and plaintext steady while the request is high. The cipher answers with a one-cycle acknowledge that carries the result. Inputs arrive one block at a time through a valid/ready pair, and each block carries a type code, a byte count and a last-block marker. A segment or digest request that breaks the ordering rules is dropped, and a sticky error flag is raised.

The controller has four states. In IDLE it accepts a hash restart, a digest request or an input block, in that priority. The transition IDLE to BLOCK_RUN fires when an in-order block is accepted. BLOCK_RUN returns to IDLE on the cipher acknowledge. The transition IDLE to DIGEST_RUN fires when a legal digest request is accepted. DIGEST_RUN goes to DIGEST_SEND on acknowledge, and the digest word is presented during DIGEST_SEND. DIGEST_SEND goes back to DIGEST_RUN for the next counter value, or to IDLE once the requested length has been covered. A rejected block or request leaves the controller in IDLE.

Top module: `typed_chain_seq`

## Requirements
- R1: After reset, and until the first accepted command, in_ready is 1 and err, cph_req, chain_valid and dig_valid are all 0.
- R2: Every cipher tweak is laid out as follows. Bits 95:0 hold the byte count of the segment up to and including the current block. Bits 119:96 are zero. Bits 125:120 hold the type code. Bit 126 marks the segment's first block and bit 127 marks its last block. Type codes are key 0, configuration 4, message 48 and output 63.
- R3: The cipher key for a segment block is the current chaining value. The plaintext is the block, with byte j taken from in_data[8j+7:8j]. After the acknowledge, the chaining value becomes cph_result XOR plaintext. A hash restart sets the chaining value to all zeros, so an unkeyed hash and the compression of a key both start from zero.
- R4: In a block with in_bytes below 64, bytes at index in_bytes and above are sent as zero, and the position field counts only the in_bytes real bytes.
- R5: A segment given as a single last block with in_bytes = 0 is processed as one all-zero block, with position 0 and both the first and last flags set.
- R6: Ordering. The first segment after a restart must have type 0 or type 4. A type-0 segment must be followed by type 4. Every later segment must have a type above the previous one and below 63. Blocks inside an open segment must repeat its type. A violating block is consumed with no cipher request, the chaining value does not change, and err is set.
- R7: err stays 1 until the next hash restart, even while later legal work is carried out.
- R8: Output block i has bytes 0 to 7 of its plaintext equal to i (little-endian) and the remaining bytes zero. Its tweak has type 63, position 8 and both flags set, and its key is the chaining value.
- R9: For a digest of N bits, output word i (i = 0, 1, ...) is the output block result XOR its plaintext, with bit b kept only when 512*i + b < N. dig_last is 1 on the word that covers bit N-1.
- R10: The output stage does not change the chaining value, so a second digest request returns the same words.
- R11: While cph_req is high and no acknowledge has arrived, cph_key, cph_tweak and cph_text do not change.
- R12: chain_valid pulses for one cycle after the acknowledge of each segment's last block, with chain_out already holding the new chaining value.
- R13: A digest request is rejected with err set, and no cipher request is made, in any of these cases: before a configuration segment, while a segment is open, or with a length of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hash_init | input | 1 | Restart: clear the chaining value, the ordering state and err (taken in IDLE) |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Controller idle; a block is taken when in_valid is 1 |
| in_type | input | 6 | Segment type code of the block |
| in_bytes | input | 7 | Real bytes in the block, 0 to 64 (64 on non-last blocks) |
| in_last | input | 1 | Block is the last of its segment |
| in_data | input | 512 | Block data, byte j in bits 8j+7:8j |
| out_req | input | 1 | Digest request (taken in IDLE) |
| out_nbits | input | 16 | Requested digest length in bits |
| cph_req | output | 1 | Cipher request, held until acknowledge |
| cph_key | output | 512 | Cipher key (chaining value) |
| cph_tweak | output | 128 | Cipher tweak |
| cph_text | output | 512 | Cipher plaintext |
| cph_ack | input | 1 | One-cycle cipher acknowledge |
| cph_result | input | 512 | Cipher output, valid with cph_ack |
| chain_valid | output | 1 | Segment completed |
| chain_out | output | 512 | Current chaining value |
| dig_valid | output | 1 | Digest word valid (one cycle) |
| dig_data | output | 512 | Truncated digest word |
| dig_last | output | 1 | Final digest word |
| err | output | 1 | Sticky ordering error |

## Verification
The bench targets the ordering corners. It repeats the configuration type after a message, opens with a message segment, changes type inside an open segment, and requests a digest before configuration. A controller that checked ordering loosely would issue a cipher request the scoreboard does not expect, or would move the chaining value so that every later word mismatches. Short and empty blocks are sent with non-zero data in the unused bytes. A padder that passed that data through, or a position field that counted padding, would spoil the cipher request comparison. Digest lengths of 5, 256, 524 and 1024 bits test the partial-byte mask, the counter step to a second output block and the exact 512-bit boundary of dig_last. A repeated request catches an output stage that overwrites the chaining value.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
    localparam int BLK_BYTES = 64;
    localparam int BLK_W     = BLK_BYTES * 8;
    localparam int CNT_W     = $clog2(BLK_BYTES) + 1;
    localparam int TWK_W     = 128;
    localparam int POS_W     = 96;
    localparam int TYPE_W    = 6;
    localparam int TY_LSB    = 120;
    localparam int RSV_W     = TY_LSB - POS_W;
    localparam int CTR_BYTES = 8;
    localparam int CTR_W     = CTR_BYTES * 8;

    typedef logic [TYPE_W-1:0] seg_type_t;

    localparam seg_type_t TY_KEY = 6'd0;
    localparam seg_type_t TY_CFG = 6'd4;
    localparam seg_type_t TY_MSG = 6'd48;
    localparam seg_type_t TY_OUT = 6'd63;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BLOCK_RUN,
        ST_DIGEST_RUN,
        ST_DIGEST_SEND
    } seq_state_t;
endpackage

// File: rtl/tbc_tweak_pack.sv
module tbc_tweak_pack
    import tbc_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  seg_type_t        ty,
    input  logic             first_blk,
    input  logic             last_blk,
    output logic [TWK_W-1:0] tweak
);
    // last flag on top, first flag below it, type field, reserved zeros, position
    assign tweak = {last_blk, first_blk, ty, {RSV_W{1'b0}}, pos};
endmodule

// File: rtl/tbc_byte_pad.sv
module tbc_byte_pad
    import tbc_pkg::*;
#(
    parameter int NBYTES = BLK_BYTES,
    parameter int NB_W   = $clog2(NBYTES) + 1
) (
    input  logic [NBYTES*8-1:0] din,
    input  logic [NB_W-1:0]     nbytes,
    output logic [NBYTES*8-1:0] dout
);
    // zero-fill every byte at or beyond the real byte count
    for (genvar j = 0; j < NBYTES; j++) begin : g_byte
        assign dout[8*j +: 8] = (int'(nbytes) > j) ? din[8*j +: 8] : 8'h00;
    end
endmodule

// File: rtl/tbc_digest_trim.sv
module tbc_digest_trim #(
    parameter int W     = 512,
    parameter int LEN_W = 16
) (
    input  logic [W-1:0]     din,
    input  logic [LEN_W-1:0] keep,
    output logic [W-1:0]     dout
);
    // bit i survives only while it lies below the remaining digest length
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[i] & (int'(keep) > i);
    end
endmodule

// File: rtl/typed_chain_seq.sv
module typed_chain_seq
    import tbc_pkg::*;
#(
    parameter int OUT_LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hash_init,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [TYPE_W-1:0]    in_type,
    input  logic [CNT_W-1:0]     in_bytes,
    input  logic                 in_last,
    input  logic [BLK_W-1:0]     in_data,
    input  logic                 out_req,
    input  logic [OUT_LEN_W-1:0] out_nbits,
    output logic                 cph_req,
    output logic [BLK_W-1:0]     cph_key,
    output logic [TWK_W-1:0]     cph_tweak,
    output logic [BLK_W-1:0]     cph_text,
    input  logic                 cph_ack,
    input  logic [BLK_W-1:0]     cph_result,
    output logic                 chain_valid,
    output logic [BLK_W-1:0]     chain_out,
    output logic                 dig_valid,
    output logic [BLK_W-1:0]     dig_data,
    output logic                 dig_last,
    output logic                 err
);
    localparam logic [OUT_LEN_W-1:0] BLK_BITS = OUT_LEN_W'(BLK_W);
    localparam int CTR_PAD = CTR_W - OUT_LEN_W;

    seq_state_t state_q, state_nx;

    logic [BLK_W-1:0]     chain_q;
    logic [BLK_W-1:0]     text_q;
    logic [TWK_W-1:0]     tweak_q;
    logic [POS_W-1:0]     pos_q;
    logic                 seg_open_q;
    seg_type_t            cur_type_q;
    seg_type_t            last_type_q;
    logic                 have_any_q;
    logic                 cfg_seen_q;
    logic                 err_q;
    logic [OUT_LEN_W-1:0] dig_ctr_q;
    logic [OUT_LEN_W-1:0] dig_left_q;
    logic                 dig_valid_q;
    logic [BLK_W-1:0]     dig_data_q;
    logic                 dig_last_q;
    logic                 chain_valid_q;

    logic                 start_ok;
    logic                 order_ok;
    logic                 out_ok;
    logic [POS_W-1:0]     pos_base;
    logic [POS_W-1:0]     pos_new;
    logic [TWK_W-1:0]     tweak_blk;
    logic [TWK_W-1:0]     tweak_out;
    logic [BLK_W-1:0]     padded;
    logic [BLK_W-1:0]     folded;
    logic [BLK_W-1:0]     trimmed;
    logic [OUT_LEN_W-1:0] ctr_next;

    // ---------------- combinational helpers ----------------
    assign start_ok = (in_type != TY_OUT) &&
                      (have_any_q ? ((in_type > last_type_q) && (cfg_seen_q || in_type == TY_CFG))
                                  : ((in_type == TY_KEY) || (in_type == TY_CFG)));
    assign order_ok = seg_open_q ? (in_type == cur_type_q) : start_ok;
    assign out_ok   = cfg_seen_q && !seg_open_q && (out_nbits != '0);

    assign pos_base = seg_open_q ? pos_q : '0;
    assign pos_new  = pos_base + {{(POS_W-CNT_W){1'b0}}, in_bytes};
    assign folded   = cph_result ^ text_q;
    assign ctr_next = dig_ctr_q + 1'b1;

    tbc_tweak_pack u_twk_blk (
        .pos       (pos_new),
        .ty        (in_type),
        .first_blk (!seg_open_q),
        .last_blk  (in_last),
        .tweak     (tweak_blk)
    );

    tbc_tweak_pack u_twk_out (
        .pos       (POS_W'(CTR_BYTES)),
        .ty        (TY_OUT),
        .first_blk (1'b1),
        .last_blk  (1'b1),
        .tweak     (tweak_out)
    );

    tbc_byte_pad #(.NBYTES(BLK_BYTES)) u_pad (
        .din    (in_data),
        .nbytes (in_bytes),
        .dout   (padded)
    );

    tbc_digest_trim #(.W(BLK_W), .LEN_W(OUT_LEN_W)) u_trim (
        .din  (folded),
        .keep (dig_left_q),
        .dout (trimmed)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hash_init) begin
                    state_nx = ST_IDLE;
                end else if (out_req) begin
                    if (out_ok) state_nx = ST_DIGEST_RUN;
                end else if (in_valid && order_ok) begin
                    state_nx = ST_BLOCK_RUN;
                end
            end
            ST_BLOCK_RUN: begin
                if (cph_ack) state_nx = ST_IDLE;
            end
            ST_DIGEST_RUN: begin
                if (cph_ack) state_nx = ST_DIGEST_SEND;
            end
            ST_DIGEST_SEND: begin
                state_nx = (dig_left_q == '0) ? ST_IDLE : ST_DIGEST_RUN;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q       <= '0;
            text_q        <= '0;
            tweak_q       <= '0;
            pos_q         <= '0;
            seg_open_q    <= 1'b0;
            cur_type_q    <= '0;
            last_type_q   <= '0;
            have_any_q    <= 1'b0;
            cfg_seen_q    <= 1'b0;
            err_q         <= 1'b0;
            dig_ctr_q     <= '0;
            dig_left_q    <= '0;
            dig_valid_q   <= 1'b0;
            dig_data_q    <= '0;
            dig_last_q    <= 1'b0;
            chain_valid_q <= 1'b0;
        end else begin
            dig_valid_q   <= 1'b0;
            chain_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (hash_init) begin
                        chain_q     <= '0;
                        pos_q       <= '0;
                        seg_open_q  <= 1'b0;
                        have_any_q  <= 1'b0;
                        cfg_seen_q  <= 1'b0;
                        last_type_q <= '0;
                        err_q       <= 1'b0;
                    end else if (out_req) begin
                        if (out_ok) begin
                            dig_ctr_q  <= '0;
                            dig_left_q <= out_nbits;
                            text_q     <= '0;
                            tweak_q    <= tweak_out;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end else if (in_valid) begin
                        if (order_ok) begin
                            text_q     <= padded;
                            tweak_q    <= tweak_blk;
                            pos_q      <= pos_new;
                            cur_type_q <= in_type;
                            seg_open_q <= !in_last;
                            if (!seg_open_q) begin
                                have_any_q  <= 1'b1;
                                last_type_q <= in_type;
                                if (in_type == TY_CFG) cfg_seen_q <= 1'b1;
                            end
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_BLOCK_RUN: begin
                    if (cph_ack) begin
                        chain_q       <= folded;
                        chain_valid_q <= tweak_q[TWK_W-1];
                    end
                end
                ST_DIGEST_RUN: begin
                    if (cph_ack) begin
                        dig_data_q  <= trimmed;
                        dig_valid_q <= 1'b1;
                        dig_last_q  <= (dig_left_q <= BLK_BITS);
                        dig_left_q  <= (dig_left_q > BLK_BITS) ? (dig_left_q - BLK_BITS) : '0;
                    end
                end
                ST_DIGEST_SEND: begin
                    dig_ctr_q <= ctr_next;
                    text_q    <= {{(BLK_W-CTR_W){1'b0}}, {CTR_PAD{1'b0}}, ctr_next};
                end
                default: ;
            endcase
        end
    end

    assign in_ready    = (state_q == ST_IDLE);
    assign cph_req     = (state_q == ST_BLOCK_RUN) || (state_q == ST_DIGEST_RUN);
    assign cph_key     = chain_q;
    assign cph_tweak   = tweak_q;
    assign cph_text    = text_q;
    assign chain_valid = chain_valid_q;
    assign chain_out   = chain_q;
    assign dig_valid   = dig_valid_q;
    assign dig_data    = dig_data_q;
    assign dig_last    = dig_last_q;
    assign err         = err_q;
endmodule

// File: rtl/tbc_seq_checker.sv
module tbc_seq_checker
    import tbc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             hash_init,
    input logic             in_ready,
    input logic             cph_req,
    input logic             cph_ack,
    input logic [BLK_W-1:0] cph_key,
    input logic [TWK_W-1:0] cph_tweak,
    input logic [BLK_W-1:0] cph_text,
    input logic             chain_valid,
    input logic [BLK_W-1:0] chain_out,
    input logic             dig_valid,
    input logic             err
);
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cph_req && !cph_ack) |=> (cph_req && $stable(cph_key) && $stable(cph_tweak) && $stable(cph_text)));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!cph_req && !dig_valid));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cph_req |-> (cph_tweak[TY_LSB-1:POS_W] == '0));

    a_r8_out_block_form: assert property (@(posedge clk) disable iff (!rst_n)
        (cph_req && cph_tweak[TY_LSB +: TYPE_W] == TY_OUT) |->
        (cph_tweak[TWK_W-1 -: 2] == 2'b11 && cph_tweak[POS_W-1:0] == POS_W'(CTR_BYTES)
         && cph_text[BLK_W-1:CTR_W] == '0));

    a_r9_digest_source: assert property (@(posedge clk) disable iff (!rst_n)
        dig_valid |-> ($past(cph_ack) && $past(cph_tweak[TY_LSB +: TYPE_W]) == TY_OUT));

    a_r12_chain_source: assert property (@(posedge clk) disable iff (!rst_n)
        chain_valid |-> ($past(cph_ack) && $past(cph_tweak[TWK_W-1])));

    a_r10_chain_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cph_req && cph_tweak[TY_LSB +: TYPE_W] == TY_OUT) |=> $stable(chain_out));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(hash_init));
endmodule

bind typed_chain_seq tbc_seq_checker u_chk (.*);

// File: tb/tb_typed_chain_seq.sv
module tb_typed_chain_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hash_init = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [5:0] in_type = '0;
    logic [6:0] in_bytes = '0;
    logic in_last = 1'b0;
    logic [511:0] in_data = '0;
    logic out_req = 1'b0;
    logic [15:0] out_nbits = '0;
    logic cph_req;
    logic [511:0] cph_key;
    logic [127:0] cph_tweak;
    logic [511:0] cph_text;
    logic cph_ack = 1'b0;
    logic [511:0] cph_result = '0;
    logic chain_valid;
    logic [511:0] chain_out;
    logic dig_valid;
    logic [511:0] dig_data;
    logic dig_last;
    logic err;

    always #(CLK_PERIOD/2) clk = ~clk;

    typed_chain_seq dut (.*);

    int n_chk = 0;
    int n_bad = 0;

    // scoreboard queues
    logic [511:0] q_key[$];
    logic [127:0] q_twk[$];
    logic [511:0] q_txt[$];
    string        q_rtag[$];
    logic [511:0] q_dig[$];
    logic         q_dlast[$];
    logic [511:0] q_chn[$];

    logic [511:0] m_chain;
    logic [95:0]  m_pos;
    bit           m_open;

    function automatic logic [511:0] toy_enc(input logic [511:0] k, input logic [127:0] t,
                                             input logic [511:0] p);
        return ({k[498:0], k[511:499]} + p) ^ {4{t}} ^ {p[255:0], p[511:256]};
    endfunction

    function automatic logic [127:0] mk_tw(input logic [95:0] pos, input logic [5:0] ty,
                                           input bit first, input bit last);
        return {last, first, ty, 24'b0, pos};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // cipher model and request monitor
    initial begin
        forever begin
            @(negedge clk);
            if (cph_req) begin
                if (q_key.size() == 0) begin
                    chk(1'b0, "R6", "unexpected cipher request tweak", {384'b0, cph_tweak}, '0);
                end else begin
                    logic [511:0] ek, et;
                    logic [127:0] ew;
                    string tg;
                    ek = q_key.pop_front(); ew = q_twk.pop_front();
                    et = q_txt.pop_front(); tg = q_rtag.pop_front();
                    chk(cph_key == ek, tg, "cipher key", cph_key, ek);
                    chk(cph_tweak == ew, tg, "cipher tweak", {384'b0, cph_tweak}, {384'b0, ew});
                    chk(cph_text == et, tg, "cipher text", cph_text, et);
                end
                repeat (LAT) @(negedge clk);
                cph_result = toy_enc(cph_key, cph_tweak, cph_text);
                cph_ack = 1'b1;
                @(negedge clk);
                cph_ack = 1'b0;
            end
        end
    end

    // digest and chain monitors
    initial begin
        forever begin
            @(negedge clk);
            if (dig_valid) begin
                if (q_dig.size() == 0) begin
                    chk(1'b0, "R9", "unexpected digest word", dig_data, '0);
                end else begin
                    logic [511:0] ed;
                    logic el;
                    ed = q_dig.pop_front(); el = q_dlast.pop_front();
                    chk(dig_data == ed, "R9", "digest word", dig_data, ed);
                    chk(dig_last == el, "R9", "digest last", {511'b0, dig_last}, {511'b0, el});
                end
            end
            if (chain_valid) begin
                if (q_chn.size() == 0) begin
                    chk(1'b0, "R12", "unexpected chain pulse", chain_out, '0);
                end else begin
                    logic [511:0] ec;
                    ec = q_chn.pop_front();
                    chk(chain_out == ec, "R12", "chain value", chain_out, ec);
                end
            end
        end
    end

    task automatic wait_idle();
        while (!in_ready) @(negedge clk);
    endtask

    task automatic do_init();
        wait_idle();
        hash_init = 1'b1;
        @(negedge clk);
        hash_init = 1'b0;
        m_chain = '0; m_pos = '0; m_open = 1'b0;
    endtask

    task automatic send_blk(input logic [5:0] ty, input int nb, input logic [511:0] d,
                            input bit last, input bit ok, input string tag);
        if (ok) begin
            logic [511:0] p;
            logic [127:0] tw;
            p = d;
            for (int j = nb; j < 64; j++) p[8*j +: 8] = 8'h00;
            if (!m_open) m_pos = '0;
            m_pos = m_pos + 96'(nb);
            tw = mk_tw(m_pos, ty, !m_open, last);
            q_key.push_back(m_chain); q_twk.push_back(tw);
            q_txt.push_back(p); q_rtag.push_back(tag);
            m_chain = toy_enc(m_chain, tw, p) ^ p;
            m_open = !last;
            if (last) q_chn.push_back(m_chain);
        end
        wait_idle();
        in_valid = 1'b1; in_type = ty; in_bytes = 7'(nb); in_last = last; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
        wait_idle();
    endtask

    task automatic run_out(input int nbits, input bit ok, input string tag);
        if (ok) begin
            for (int i = 0; i * 512 < nbits; i++) begin
                logic [511:0] txt, r;
                logic [127:0] tw;
                int rem;
                txt = {448'b0, 64'(i)};
                tw = mk_tw(96'd8, 6'd63, 1'b1, 1'b1);
                q_key.push_back(m_chain); q_twk.push_back(tw);
                q_txt.push_back(txt); q_rtag.push_back(tag);
                r = toy_enc(m_chain, tw, txt) ^ txt;
                rem = nbits - 512 * i;
                for (int b = 0; b < 512; b++) if (b >= rem) r[b] = 1'b0;
                q_dig.push_back(r);
                q_dlast.push_back(rem <= 512);
            end
        end
        wait_idle();
        out_req = 1'b1; out_nbits = 16'(nbits);
        @(negedge clk);
        out_req = 1'b0;
        wait_idle();
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_err(input logic v, input string tag);
        chk(err == v, tag, "err flag", {511'b0, err}, {511'b0, v});
    endtask

    task automatic finish_run();
        chk(q_key.size() == 0, "R3", "cipher requests left over", 512'(q_key.size()), '0);
        chk(q_dig.size() == 0, "R9", "digest words left over", 512'(q_dig.size()), '0);
        chk(q_chn.size() == 0, "R12", "chain pulses left over", 512'(q_chn.size()), '0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R11 watchdog: actual hung, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [511:0] pat_a, pat_b, junk;
        pat_a = {8{64'h0123_4567_89ab_cdef}};
        pat_b = {16{32'h5a5a_c3e1}} ^ {8{64'h1111_0000_ffff_2222}};
        junk  = {16{32'hdead_beef}};
        m_chain = '0; m_pos = '0; m_open = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "in_ready after reset", {511'b0, in_ready}, 512'd1);
        chk(err == 1'b0, "R1", "err after reset", {511'b0, err}, '0);
        chk(cph_req == 1'b0, "R1", "cph_req after reset", {511'b0, cph_req}, '0);
        chk(dig_valid == 1'b0 && chain_valid == 1'b0, "R1", "pulses after reset",
            {510'b0, dig_valid, chain_valid}, '0);

        // unkeyed hash: short config (R4), two-block message (R2), digests
        do_init();
        send_blk(6'd4, 32, pat_a ^ junk, 1'b1, 1'b1, "R4");
        send_blk(6'd48, 64, pat_a, 1'b0, 1'b1, "R2");
        send_blk(6'd48, 20, pat_b, 1'b1, 1'b1, "R2");
        run_out(256, 1'b1, "R8");
        run_out(5, 1'b1, "R9");
        run_out(524, 1'b1, "R8");
        run_out(256, 1'b1, "R10");
        chk(chain_out == m_chain, "R10", "chain after output stage", chain_out, m_chain);

        // R6: configuration again after message is rejected
        send_blk(6'd4, 64, pat_b, 1'b1, 1'b0, "R6");
        expect_err(1'b1, "R6");
        chk(chain_out == m_chain, "R6", "chain after rejected block", chain_out, m_chain);
        // R7 err stays while an empty higher segment is processed (R5)
        send_blk(6'd50, 0, junk, 1'b1, 1'b1, "R5");
        expect_err(1'b1, "R7");
        run_out(64, 1'b1, "R8");
        expect_err(1'b1, "R7");
        do_init();
        expect_err(1'b0, "R7");

        // keyed hash: key compressed from zero (R3), config, empty message (R5)
        send_blk(6'd0, 64, pat_b, 1'b1, 1'b1, "R3");
        send_blk(6'd4, 32, pat_a, 1'b1, 1'b1, "R3");
        send_blk(6'd48, 0, junk, 1'b1, 1'b1, "R5");
        run_out(1024, 1'b1, "R8");
        expect_err(1'b0, "R6");

        // R6: message as first segment
        do_init();
        send_blk(6'd48, 64, pat_a, 1'b1, 1'b0, "R6");
        expect_err(1'b1, "R6");
        chk(chain_out == '0, "R6", "chain after rejected first block", chain_out, '0);

        // R13: digest before configuration
        do_init();
        run_out(128, 1'b0, "R13");
        expect_err(1'b1, "R13");

        // R13: zero length; R6: type change inside open segment; R13: digest while open
        do_init();
        send_blk(6'd4, 64, pat_a, 1'b1, 1'b1, "R3");
        run_out(0, 1'b0, "R13");
        expect_err(1'b1, "R13");
        do_init();
        send_blk(6'd4, 64, pat_a, 1'b1, 1'b1, "R3");
        send_blk(6'd48, 64, pat_b, 1'b0, 1'b1, "R2");
        send_blk(6'd52, 64, pat_a, 1'b1, 1'b0, "R6");
        expect_err(1'b1, "R6");
        run_out(64, 1'b0, "R13");
        send_blk(6'd48, 7, pat_a, 1'b1, 1'b1, "R4");
        run_out(300, 1'b1, "R9");

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule